// File: doc/BRIEF.md
# Chained-Descriptor Memory Copy Channel

This block is one DMA channel that copies a sequence of memory blocks without processor help. Software writes the first descriptor into the channel registers: a source address, a destination address, a pointer to the next descriptor and a control word. It then sets the enable bit. The channel copies that block one word at a time. It then reads the next four-word descriptor from memory, replaces all four register values at once, and copies that block. This repeats until a descriptor with a null next pointer has been processed. The channel then clears its own enable bit.

Each word is copied with a read from the source followed by a write to the destination. Both go over a single word-wide master port with a request/ready handshake. Source and destination addresses can each step by one word or stay fixed, so a peripheral data register can be the target. Any descriptor can request a completion flag. The flag raises the interrupt line when the global mask bit is set. Software clears the flag by writing a one to it.

Top module: `sg_dma_channel`

## Requirements
- R1: After reset, `ch_en`, `irq` and `m_req` are 0.
- R2: For a block of N words (control word bits 11:0 = N), the channel makes N source reads. Each read is followed directly by one write of the read value to the destination, so the destination ends up holding a copy of the source words.
- R3: Control bit 26 set makes the source address step by 4 after each word, and control bit 27 does the same for the destination. A cleared bit keeps that address fixed for the whole block.
- R4: A descriptor is fetched by four reads at next, next+4, next+8 and next+12, in that order. These give the source, destination, next pointer and control word. The four registers change together, once the fourth word has arrived.
- R5: After a block whose next pointer is 0, `ch_en` falls to 0 and the master port stays idle.
- R6: A block of size 0 makes no source or destination access. The channel goes straight on to the completion check and the next-descriptor fetch.
- R7: Control bit 31 set makes the completion flag go to 1 at the end of that block. The flag holds until bit 0 is written as 1 at register address 5. Writing 0 there has no effect. A block with bit 31 clear leaves the flag unchanged.
- R8: `irq` is high exactly when the completion flag is set and the mask bit (bit 1 at register address 4) is 1.
- R9: Clearing the enable bit (bit 0 at register address 4) stops the channel once the word in flight has been written. Setting the bit again resumes the copy with no word lost or repeated.
- R10: The first block uses the register contents written by software. No descriptor fetch happens before that block is done.
- R11: While `m_req` is high and `m_ready` is low, `m_addr`, `m_we` and `m_wdata` stay stable and `m_req` stays high.

Register addresses used by the bench are 0 source, 1 destination, 2 next pointer, 3 control, 4 configuration and 5 flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| m_req | output | 1 | Master request |
| m_we | output | 1 | Master write (1) or read (0) |
| m_addr | output | 32 | Master byte address |
| m_wdata | output | 32 | Master write data |
| m_ready | input | 1 | Slave accepts the request in this cycle |
| m_rdata | input | 32 | Read data, valid when `m_ready` is high |
| ch_en | output | 1 | Channel enable bit |
| irq | output | 1 | Masked completion interrupt |

## Verification
The assertions rely on software not writing the address, pointer or control registers while the channel is enabled. Without that rule, request stability and the rule that a nonzero count precedes every word step would not hold. They also rely on a memory that returns read data in the same cycle as `m_ready`. The bench writes registers only while `ch_en` is low, apart from the deliberate disable write in the halt test. Its memory model answers combinationally, with `m_ready` either held high or stalled two cycles out of three.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WR,
      ST_CHK,
      ST_FETCH
   } eng_state_e;

   // control word field positions
   localparam int CTL_SINC_BIT = 26;
   localparam int CTL_DINC_BIT = 27;
   localparam int CTL_TC_BIT   = 31;

   // register addresses
   localparam logic [2:0] RA_SRC = 3'd0;
   localparam logic [2:0] RA_DST = 3'd1;
   localparam logic [2:0] RA_NXT = 3'd2;
   localparam logic [2:0] RA_CTL = 3'd3;
   localparam logic [2:0] RA_CFG = 3'd4;
   localparam logic [2:0] RA_CLR = 3'd5;
endpackage

// File: rtl/sg_dma_regs.sv
module sg_dma_regs
   import sg_dma_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_addr,
   input  logic [31:0]      cfg_wdata,
   input  logic             step_i,
   input  logic             load_i,
   input  logic [AW-1:0]    ld_src_i,
   input  logic [AW-1:0]    ld_dst_i,
   input  logic [AW-1:0]    ld_nxt_i,
   input  logic [31:0]      ld_ctl_i,
   input  logic             set_tc_i,
   input  logic             clr_en_i,
   output logic [AW-1:0]    src_o,
   output logic [AW-1:0]    dst_o,
   output logic [AW-1:0]    nxt_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             tc_en_o,
   output logic             en_o,
   output logic             mask_o,
   output logic             tc_o
);
   localparam logic [AW-1:0] WORD_STEP = AW'(4);

   logic [AW-1:0]    src_q, dst_q, nxt_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sinc_q, dinc_q, tc_en_q;
   logic             en_q, mask_q, tc_q;

   logic unused_ctl_bits;
   assign unused_ctl_bits = ^{ld_ctl_i[30:28], ld_ctl_i[25:CNT_W],
                              cfg_wdata[30:28], cfg_wdata[25:CNT_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= '0;
         dst_q   <= '0;
         nxt_q   <= '0;
         cnt_q   <= '0;
         sinc_q  <= 1'b0;
         dinc_q  <= 1'b0;
         tc_en_q <= 1'b0;
         en_q    <= 1'b0;
         mask_q  <= 1'b0;
         tc_q    <= 1'b0;
      end else begin
         // engine-side updates
         if (step_i) begin
            if (sinc_q) src_q <= src_q + WORD_STEP;
            if (dinc_q) dst_q <= dst_q + WORD_STEP;
            cnt_q <= cnt_q - CNT_W'(1);
         end
         if (load_i) begin
            src_q   <= ld_src_i;
            dst_q   <= ld_dst_i;
            nxt_q   <= ld_nxt_i;
            cnt_q   <= ld_ctl_i[CNT_W-1:0];
            sinc_q  <= ld_ctl_i[CTL_SINC_BIT];
            dinc_q  <= ld_ctl_i[CTL_DINC_BIT];
            tc_en_q <= ld_ctl_i[CTL_TC_BIT];
         end
         if (set_tc_i) tc_q <= 1'b1;
         if (clr_en_i) en_q <= 1'b0;
         // software writes take precedence
         if (cfg_we) begin
            unique case (cfg_addr)
               RA_SRC: src_q <= cfg_wdata[AW-1:0];
               RA_DST: dst_q <= cfg_wdata[AW-1:0];
               RA_NXT: nxt_q <= cfg_wdata[AW-1:0];
               RA_CTL: begin
                  cnt_q   <= cfg_wdata[CNT_W-1:0];
                  sinc_q  <= cfg_wdata[CTL_SINC_BIT];
                  dinc_q  <= cfg_wdata[CTL_DINC_BIT];
                  tc_en_q <= cfg_wdata[CTL_TC_BIT];
               end
               RA_CFG: begin
                  en_q   <= cfg_wdata[0];
                  mask_q <= cfg_wdata[1];
               end
               RA_CLR: if (cfg_wdata[0]) tc_q <= 1'b0;
               default: ;
            endcase
         end
      end
   end

   assign src_o   = src_q;
   assign dst_o   = dst_q;
   assign nxt_o   = nxt_q;
   assign cnt_o   = cnt_q;
   assign tc_en_o = tc_en_q;
   assign en_o    = en_q;
   assign mask_o  = mask_q;
   assign tc_o    = tc_q;

   // R7: flag only drops through a write of 1 to the clear register
   p_tc_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_q && !(cfg_we && cfg_addr == RA_CLR && cfg_wdata[0])) |=> tc_q);
   // R6: a word step never happens with an empty count
   p_step_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> (cnt_q != '0));
   // R5: the engine ends the chain only on a null pointer
   p_end_on_null_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en_i |-> (nxt_q == '0));
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
   import sg_dma_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [AW-1:0]    src_i,
   input  logic [AW-1:0]    dst_i,
   input  logic [AW-1:0]    nxt_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             tc_en_i,
   output logic             m_req,
   output logic             m_we,
   output logic [AW-1:0]    m_addr,
   output logic [31:0]      m_wdata,
   input  logic             m_ready,
   input  logic [31:0]      m_rdata,
   output logic             step_o,
   output logic             load_o,
   output logic [AW-1:0]    ld_src_o,
   output logic [AW-1:0]    ld_dst_o,
   output logic [AW-1:0]    ld_nxt_o,
   output logic [31:0]      ld_ctl_o,
   output logic             set_tc_o,
   output logic             clr_en_o
);
   eng_state_e    st_q, st_d;
   logic [31:0]   data_q;
   logic [1:0]    idx_q;
   logic [AW-1:0] f_src_q, f_dst_q, f_nxt_q;
   logic          hs, last_fetch;

   assign hs         = m_req && m_ready;
   assign last_fetch = (st_q == ST_FETCH) && hs && (idx_q == 2'd3);

   always_comb begin
      m_req  = (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_FETCH);
      m_we   = (st_q == ST_WR);
      unique case (st_q)
         ST_RD:    m_addr = src_i;
         ST_WR:    m_addr = dst_i;
         ST_FETCH: m_addr = nxt_i + {{(AW-4){1'b0}}, idx_q, 2'b00};
         default:  m_addr = '0;
      endcase
   end
   assign m_wdata = data_q;

   assign step_o   = (st_q == ST_WR) && hs;
   assign load_o   = last_fetch;
   assign ld_src_o = f_src_q;
   assign ld_dst_o = f_dst_q;
   assign ld_nxt_o = f_nxt_q;
   assign ld_ctl_o = m_rdata;
   assign set_tc_o = (st_q == ST_CHK) && tc_en_i;
   assign clr_en_o = (st_q == ST_CHK) && (nxt_i == '0);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (en_i) st_d = (cnt_i == '0) ? ST_CHK : ST_RD;
         ST_RD:    if (hs) st_d = ST_WR;
         ST_WR:    if (hs) st_d = (en_i && cnt_i != CNT_W'(1)) ? ST_RD : ST_IDLE;
         ST_CHK:   st_d = (nxt_i == '0) ? ST_IDLE : ST_FETCH;
         ST_FETCH: if (last_fetch) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         data_q  <= '0;
         idx_q   <= '0;
         f_src_q <= '0;
         f_dst_q <= '0;
         f_nxt_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_RD && hs) data_q <= m_rdata;
         if (st_q == ST_CHK) idx_q <= '0;
         if (st_q == ST_FETCH && hs) begin
            idx_q <= idx_q + 2'd1;
            unique case (idx_q)
               2'd0:    f_src_q <= m_rdata[AW-1:0];
               2'd1:    f_dst_q <= m_rdata[AW-1:0];
               2'd2:    f_nxt_q <= m_rdata[AW-1:0];
               default: ;
            endcase
         end
      end
   end

   // R11: a pending request keeps its attributes
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));
   // R2: an accepted source read is followed by the destination write
   p_wr_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RD && hs) |=> (m_req && m_we));
   // R9: a disabled idle channel issues nothing
   p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !en_i) |=> !m_req);
   // R4: descriptor words are read at ascending word addresses
   p_fetch_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FETCH && hs && idx_q != 2'd3) |=>
      (m_req && !m_we && m_addr == $past(m_addr) + AW'(4)));
endmodule

// File: rtl/sg_dma_channel.sv
module sg_dma_channel #(
   parameter int AW      = 32,
   parameter int CNT_W   = 12,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [31:0]   cfg_wdata,
   output logic          m_req,
   output logic          m_we,
   output logic [AW-1:0] m_addr,
   output logic [31:0]   m_wdata,
   input  logic          m_ready,
   input  logic [31:0]   m_rdata,
   output logic          ch_en,
   output logic          irq
);
   initial begin
      if (AW < 8 || AW > 32) $fatal(1, "sg_dma_channel: AW must lie in 8..32");
      if (CNT_W < 1 || CNT_W > 25) $fatal(1, "sg_dma_channel: CNT_W must lie in 1..25");
   end

   logic [AW-1:0]    src, dst, nxt, ld_src, ld_dst, ld_nxt;
   logic [CNT_W-1:0] cnt;
   logic [31:0]      ld_ctl;
   logic             tc_en, mask, tc, step, load, set_tc, clr_en;

   sg_dma_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .step_i(step), .load_i(load),
      .ld_src_i(ld_src), .ld_dst_i(ld_dst), .ld_nxt_i(ld_nxt), .ld_ctl_i(ld_ctl),
      .set_tc_i(set_tc), .clr_en_i(clr_en),
      .src_o(src), .dst_o(dst), .nxt_o(nxt), .cnt_o(cnt), .tc_en_o(tc_en),
      .en_o(ch_en), .mask_o(mask), .tc_o(tc)
   );

   sg_dma_engine #(.AW(AW), .CNT_W(CNT_W)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .en_i(ch_en), .src_i(src), .dst_i(dst), .nxt_i(nxt), .cnt_i(cnt), .tc_en_i(tc_en),
      .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_ready(m_ready), .m_rdata(m_rdata),
      .step_o(step), .load_o(load),
      .ld_src_o(ld_src), .ld_dst_o(ld_dst), .ld_nxt_o(ld_nxt), .ld_ctl_o(ld_ctl),
      .set_tc_o(set_tc), .clr_en_o(clr_en)
   );

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= tc && mask;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = tc && mask;
      end
   endgenerate

   // R1: nothing is requested while the channel has never been enabled
   p_no_req_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!ch_en) && !ch_en && !m_req) |=> !m_req);
endmodule

// File: tb/tb_sg_dma_channel.sv
module tb_sg_dma_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        m_req, m_we, m_ready, ch_en, irq;
   logic [31:0] m_addr, m_wdata, m_rdata;

   int n_chk = 0, n_err = 0;
   int nrd = 0, nwr = 0, n_fix = 0, n_zero_src = 0, n_first_desc = 0;
   logic [31:0] rlog [0:127];
   logic [31:0] mem [0:4095];
   bit  stall = 1'b0;
   int  rdy_ctr = 0;

   always #10 clk = ~clk;

   sg_dma_channel dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_ready(m_ready), .m_rdata(m_rdata), .ch_en(ch_en), .irq(irq)
   );

   assign m_rdata = mem[m_addr[13:2]];

   always @(negedge clk) begin
      rdy_ctr <= rdy_ctr + 1;
      m_ready <= !stall || (rdy_ctr % 3 == 2);
   end

   always @(posedge clk) begin
      if (m_req && m_ready) begin
         if (m_we) begin
            mem[m_addr[13:2]] <= m_wdata;
            nwr <= nwr + 1;
            if (m_addr == 32'h3000) n_fix <= n_fix + 1;
         end else begin
            if (nrd < 128) rlog[nrd] <= m_addr;
            nrd <= nrd + 1;
            if (m_addr >= 32'h1100 && m_addr < 32'h1110) n_zero_src <= n_zero_src + 1;
            if (m_addr >= 32'h20000 && m_addr < 32'h20010) n_first_desc <= n_first_desc + 1;
         end
      end
   end

   function automatic logic [31:0] pat(input int k);
      return 32'hC0DE_0000 ^ (k * 32'h0001_0107);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_desc(input logic [31:0] s, d, n, c);
      reg_wr(3'd0, s); reg_wr(3'd1, d); reg_wr(3'd2, n); reg_wr(3'd3, c);
   endtask

   task automatic put_desc(input int at, input logic [31:0] s, d, n, c);
      mem[at[13:2]]     = s;
      mem[at[13:2] + 1] = d;
      mem[at[13:2] + 2] = n;
      mem[at[13:2] + 3] = c;
   endtask

   task automatic wait_done(input string tag);
      int k = 0;
      while (ch_en && k < 5000) begin @(negedge clk); k++; end
      repeat (3) @(negedge clk);
      chk(!ch_en && !m_req, tag, {30'd0, ch_en, m_req}, 32'd0);
   endtask

   localparam logic [31:0] INC2 = 32'h0C00_0000;
   localparam logic [31:0] TCB  = 32'h8000_0000;

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R5 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int b_rd, b_wr, b_fix, pos;
      for (int k = 0; k < 4096; k++) mem[k] = (k >= 12'h400 && k < 12'h600) ? pat(k) : 32'd0;
      repeat (3) @(negedge clk);
      chk(!ch_en && !irq && !m_req, "R1 reset outputs", {29'd0, ch_en, irq, m_req}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!ch_en && !irq && !m_req, "R1 after release", {29'd0, ch_en, irq, m_req}, 32'd0);

      // ---- chain of three contiguous descriptors, completion flag on last
      put_desc(32'h20000, 32'h1000, 32'h2000, 32'h20010, INC2 | 32'd5);
      put_desc(32'h20010, 32'h1014, 32'h2014, 32'h20020, INC2 | 32'd3);
      put_desc(32'h20020, 32'h1020, 32'h2020, 32'h0,     TCB | INC2 | 32'd4);
      load_desc(32'h1000, 32'h2000, 32'h20010, INC2 | 32'd5);
      b_rd = nrd; b_wr = nwr;
      reg_wr(3'd4, 32'd3);
      wait_done("R5 chain stops on null pointer");
      for (int i = 0; i < 12; i++)
         chk(mem[12'h800 + i] == pat(12'h400 + i), "R2 R3 copied word", mem[12'h800 + i], pat(12'h400 + i));
      chk(nrd - b_rd == 20, "R4 read count", nrd - b_rd, 20);
      chk(nwr - b_wr == 12, "R2 write count", nwr - b_wr, 12);
      chk(n_first_desc == 0, "R10 first descriptor not fetched", n_first_desc, 0);
      pos = -1;
      for (int i = b_rd; i < nrd; i++) if (pos < 0 && rlog[i] == 32'h20010) pos = i;
      chk(pos == b_rd + 5, "R10 fetch after first block", pos, b_rd + 5);
      for (int j = 1; j < 4; j++)
         chk(pos >= 0 && rlog[pos + j] == 32'h20010 + 4 * j, "R4 fetch order",
             (pos >= 0) ? rlog[pos + j] : 32'hx, 32'h20010 + 4 * j);
      b_rd = nrd; b_wr = nwr;
      repeat (10) @(negedge clk);
      chk(nrd == b_rd && nwr == b_wr, "R5 port idle after end", nrd + nwr - b_rd - b_wr, 0);
      chk(irq == 1'b1, "R7 R8 flag raised", irq, 1);
      reg_wr(3'd5, 32'd0);
      @(negedge clk);
      chk(irq == 1'b1, "R7 write of 0 ignored", irq, 1);
      reg_wr(3'd5, 32'd1);
      @(negedge clk);
      chk(irq == 1'b0, "R7 write of 1 clears", irq, 0);

      // ---- masked flag
      load_desc(32'h1040, 32'h2100, 32'h0, TCB | INC2 | 32'd2);
      reg_wr(3'd4, 32'd1);
      wait_done("R5 single block end");
      chk(irq == 1'b0, "R8 masked", irq, 0);
      reg_wr(3'd4, 32'd2);
      @(negedge clk);
      chk(irq == 1'b1, "R8 unmasked shows held flag", irq, 1);
      chk(mem[12'h841] == pat(12'h411), "R2 second word", mem[12'h841], pat(12'h411));
      reg_wr(3'd5, 32'd1);

      // ---- zero-size block then fixed destination, stalled memory
      stall = 1'b1;
      put_desc(32'h20040, 32'h1200, 32'h3000, 32'h0, 32'h0400_0000 | 32'd6);
      load_desc(32'h1100, 32'h2200, 32'h20040, INC2);
      b_rd = nrd; b_wr = nwr; b_fix = n_fix;
      reg_wr(3'd4, 32'd3);
      wait_done("R5 end after zero block chain");
      chk(n_zero_src == 0, "R6 no access for empty block", n_zero_src, 0);
      chk(nrd - b_rd == 10, "R6 reads incl fetch", nrd - b_rd, 10);
      chk(n_fix - b_fix == 6, "R3 fixed destination writes", n_fix - b_fix, 6);
      chk(nwr - b_wr == 6, "R3 all writes fixed", nwr - b_wr, 6);
      chk(mem[12'hC00] == pat(12'h485), "R3 last value at fixed address", mem[12'hC00], pat(12'h485));
      chk(irq == 1'b0, "R7 no flag without bit 31", irq, 0);

      // ---- zero-size final block with flag
      b_rd = nrd; b_wr = nwr;
      load_desc(32'h1100, 32'h2200, 32'h0, TCB | INC2);
      reg_wr(3'd4, 32'd3);
      wait_done("R5 zero block end");
      chk(nrd == b_rd && nwr == b_wr, "R6 zero block no access", nrd + nwr - b_rd - b_wr, 0);
      chk(irq == 1'b1, "R6 R7 flag after empty block", irq, 1);
      reg_wr(3'd5, 32'd1);

      // ---- halt and resume
      b_rd = nrd; b_wr = nwr;
      load_desc(32'h1400, 32'h2400, 32'h0, INC2 | 32'd8);
      reg_wr(3'd4, 32'd1);
      while (nwr - b_wr < 3) @(negedge clk);
      reg_wr(3'd4, 32'd0);
      repeat (30) @(negedge clk);
      pos = nwr - b_wr;
      chk(pos >= 3 && pos < 8, "R9 halted mid block", pos, 4);
      chk(nrd - b_rd == pos, "R9 no dangling read", nrd - b_rd, pos);
      repeat (20) @(negedge clk);
      chk(nwr - b_wr == pos, "R9 stays halted", nwr - b_wr, pos);
      reg_wr(3'd4, 32'd1);
      wait_done("R9 resumed block ends");
      chk(nwr - b_wr == 8, "R9 no repeated word", nwr - b_wr, 8);
      chk(nrd - b_rd == 8, "R9 no repeated read", nrd - b_rd, 8);
      for (int i = 0; i < 8; i++)
         chk(mem[12'h900 + i] == pat(12'h500 + i), "R9 word after resume", mem[12'h900 + i], pat(12'h500 + i));

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule